// File: doc/BRIEF.md
# Interrupt Redirection Controller

This block turns a set of device interrupt lines into delivery requests for a processor-side dispatcher. Each input pin owns a 64-bit redirection entry that says which vector to raise, how the request is to be routed, whether the pin is edge or level sensitive, which electrical sense counts as asserted, and whether the pin is masked. Software programs the entries, the controller ID and the version word through a two-register indirect scheme: an index register picks a target and a data window reads or writes it, one 32-bit half of an entry at a time.

Edge pins raise a request on every rising assertion. Level pins use an in-service flag: a level pin delivers only while the flag is clear, sets it when it delivers, and stays quiet until software posts an end-of-interrupt for the pin's vector. The EOI clears the flag on every pin that carries that vector, and any such level pin whose line is still asserted is delivered again at once. Pending requests are presented one at a time on a valid/ready port, lowest pin number first, with the routing fields of the chosen pin. Which CPU finally takes the interrupt is decided downstream.

Top module: `irq_redir_ctrl`

## Requirements
- R1: A bus write to offset 0x00 stores bits [7:0] as the index; a read of offset 0x00 returns that index in bits [7:0]. Offset 0x10 is the data window onto the indexed register; reads of any offset other than 0x00 and 0x10 return zero.
- R2: Index 1 is the version word: bits [7:0] hold the VERSION parameter (0x20 by default), bits [23:16] hold the pin count minus one, all other bits read zero, and window writes to it change nothing.
- R3: Index 0 is the ID register: a window write stores bits [27:24] as the 4-bit ID and a read returns it in bits [27:24]. Index 2 reads back the same ID word, and window writes to index 2 change nothing.
- R4: Index 0x10 + 2n is the low word and index 0x11 + 2n the high word of pin n's entry. Low-word fields: vector [7:0], delivery mode [10:8], destination mode [11], delivery status [12], polarity [13], in-service flag [14], trigger [15] (1 = level), mask [16]; the high word carries the destination in [31:24]; every other bit reads zero.
- R5: An entry index that names a pin at or beyond the pin count reads zero and ignores writes.
- R6: A low-word write leaves the in-service flag unchanged and forces delivery status to zero; both bits ignore the written data. A high-word write changes only the destination and never raises a delivery.
- R7: After a low-word write, an edge pin has its in-service flag cleared; a level pin that is unmasked, has the flag clear and whose line is asserted sets the flag and raises a delivery in the same cycle.
- R8: On a rising assertion a masked pin does nothing; an unmasked edge pin raises a delivery on every rising assertion; an unmasked level pin raises a delivery and sets its flag only if the flag was clear.
- R9: A bus write to offset 0x40 is an EOI with the vector in bits [7:0]: it clears the in-service flag of every pin whose vector matches, and any such pin that is level, unmasked and still asserted sets the flag again and raises a new delivery. Pins with other vectors are untouched.
- R10: A pin's line counts as asserted when its input XOR its polarity bit is 1 (polarity 1 = active low); a low-word write evaluates the new polarity.
- R11: Raised deliveries stay pending until accepted with dlv_valid and dlv_ready high on the same edge; dlv_valid stays high while any are pending; the lowest pending pin is presented, with its vector, delivery mode, destination mode, destination and trigger fields.
- R12: After reset every entry reads 0x00010000 low and zero high (only mask set), the ID is zero, the index is zero and no delivery is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_in | input | NUM_PINS | Raw interrupt input lines |
| dlv_valid | output | 1 | A delivery is pending |
| dlv_ready | input | 1 | Dispatcher accepts the presented delivery |
| dlv_pin | output | PIN_W | Pin number of the presented delivery |
| dlv_vector | output | 8 | Vector of the presented pin |
| dlv_mode | output | 3 | Delivery mode field |
| dlv_dest_mode | output | 1 | Destination mode field |
| dlv_dest | output | 8 | Destination field |
| dlv_level | output | 1 | Trigger field (1 = level) |

## Verification
The bench builds the controller with four pins, so the version word carries a pin-count field of 3 and entry index 0x18 already lies beyond the last pin, which makes the out-of-range read and write path reachable with a short index sweep. Four pins are also enough to hold an edge pin, a level pin and an active-low level pin side by side while two edge pins fire in the same cycle to exercise lowest-first ordering and the hold of an unaccepted request. The level-pin sequences walk the in-service flag through write-time delivery, a blocked re-edge, an EOI with a matching and a non-matching vector, and a switch to edge mode.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;

    // Bus offsets
    localparam logic [7:0] OFF_SEL = 8'h00;
    localparam logic [7:0] OFF_WIN = 8'h10;
    localparam logic [7:0] OFF_EOI = 8'h40;

    // Indirect indexes
    localparam logic [7:0] IDX_ID  = 8'h00;
    localparam logic [7:0] IDX_VER = 8'h01;
    localparam logic [7:0] IDX_ARB = 8'h02;
    localparam logic [7:0] IDX_TBL = 8'h10;

    typedef enum logic [2:0] {
        K_NONE,
        K_ID,
        K_VER,
        K_ARB,
        K_ENT
    } win_kind_e;

    // One redirection entry, MSB first (bit positions are software-visible)
    typedef struct packed {
        logic [7:0]  dest;      // 63:56
        logic [38:0] rsvd;      // 55:17
        logic        mask;      // 16
        logic        level;     // 15
        logic        in_svc;    // 14
        logic        pol;       // 13
        logic        dstat;     // 12
        logic        dmode;     // 11
        logic [2:0]  dlv;       // 10:8
        logic [7:0]  vec;       // 7:0
    } rte_t;

    typedef struct packed {
        logic [7:0] sel;
        logic [3:0] id;
    } ctl_t;

    localparam rte_t RTE_RESET = '{mask: 1'b1, default: '0};

endpackage

// File: rtl/irq_line_sense.sv
module irq_line_sense #(
    parameter int NUM_PINS = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] irq_in,
    input  logic [NUM_PINS-1:0] pol,
    output logic [NUM_PINS-1:0] asserted,
    output logic [NUM_PINS-1:0] rise
);

    logic [NUM_PINS-1:0] line_d, line_q;

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        // polarity 1 means the pin is active low
        assign asserted[g] = irq_in[g] ^ pol[g];
        assign rise[g]     = asserted[g] & ~line_q[g];
    end

    always_comb begin
        line_d = asserted;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= '0;
        else        line_q <= line_d;
    end

endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
    parameter int NUM_PINS = 24,
    parameter int PIN_W    = 5
) (
    input  logic [NUM_PINS-1:0] req,
    output logic                gnt_valid,
    output logic [PIN_W-1:0]    gnt_idx
);

    always_comb begin
        gnt_idx = '0;
        for (int i = NUM_PINS - 1; i >= 0; i--) begin
            if (req[i]) gnt_idx = PIN_W'(i);
        end
        gnt_valid = |req;
    end

endmodule

// File: rtl/irq_redir_decode.sv
module irq_redir_decode
    import irq_redir_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int PIN_W    = 5
) (
    input  logic [7:0]       sel,
    output win_kind_e        kind,
    output logic [PIN_W-1:0] ent_idx,
    output logic             ent_hi
);

    logic [7:0] off;
    logic [6:0] num;
    logic       unused_off;

    always_comb begin
        off    = sel - IDX_TBL;
        num    = off[7:1];
        ent_hi = sel[0];
        ent_idx = num[PIN_W-1:0];
        kind   = K_NONE;
        case (sel)
            IDX_ID:  kind = K_ID;
            IDX_VER: kind = K_VER;
            IDX_ARB: kind = K_ARB;
            default: begin
                if (sel >= IDX_TBL && int'(num) < NUM_PINS) kind = K_ENT;
            end
        endcase
    end

    assign unused_off = off[0];

endmodule

// File: rtl/irq_redir_ctrl.sv
module irq_redir_ctrl
    import irq_redir_pkg::*;
#(
    parameter int         NUM_PINS = 24,
    parameter logic [7:0] VERSION  = 8'h20,
    localparam int        PIN_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [7:0]          bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PINS-1:0] irq_in,
    output logic                dlv_valid,
    input  logic                dlv_ready,
    output logic [PIN_W-1:0]    dlv_pin,
    output logic [7:0]          dlv_vector,
    output logic [2:0]          dlv_mode,
    output logic                dlv_dest_mode,
    output logic [7:0]          dlv_dest,
    output logic                dlv_level
);

    localparam logic [7:0]  ENTRIES_M1 = 8'(NUM_PINS - 1);
    localparam logic [31:0] VER_WORD   = {8'h00, ENTRIES_M1, 8'h00, VERSION};

    // State
    ctl_t                ctl_d, ctl_q;
    rte_t                tbl_d [NUM_PINS];
    rte_t                tbl_q [NUM_PINS];
    logic [NUM_PINS-1:0] pend_d, pend_q;

    // Helpers
    logic [NUM_PINS-1:0] pol_v, asserted, rise;
    win_kind_e           kind;
    logic [PIN_W-1:0]    ent_idx, gnt_idx;
    logic                ent_hi, gnt_valid;
    logic                win_wr, eoi_wr;
    rte_t                win_ent, gnt_ent;
    logic [7:0]          sel_cur;
    logic                unused_wdata;

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pol
        assign pol_v[g] = tbl_q[g].pol;
    end

    irq_line_sense #(.NUM_PINS(NUM_PINS)) u_sense (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_in   (irq_in),
        .pol      (pol_v),
        .asserted (asserted),
        .rise     (rise)
    );

    irq_redir_decode #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_dec (
        .sel     (ctl_q.sel),
        .kind    (kind),
        .ent_idx (ent_idx),
        .ent_hi  (ent_hi)
    );

    irq_lowest_pick #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_pick (
        .req       (pend_q),
        .gnt_valid (gnt_valid),
        .gnt_idx   (gnt_idx)
    );

    assign win_wr  = bus_wr && (bus_addr == OFF_WIN);
    assign eoi_wr  = bus_wr && (bus_addr == OFF_EOI);
    assign sel_cur = ctl_q.sel;
    assign unused_wdata = ^bus_wdata[23:17];

    // Next-state computation
    always_comb begin
        rte_t e;
        logic raise;

        ctl_d  = ctl_q;
        tbl_d  = tbl_q;
        pend_d = pend_q;

        // R11: accepted request leaves the pending set
        if (gnt_valid && dlv_ready) pend_d[gnt_idx] = 1'b0;

        // R1: index register
        if (bus_wr && bus_addr == OFF_SEL) ctl_d.sel = bus_wdata[7:0];

        // R3: only index 0 takes the ID; index 1 and 2 ignore writes (R2)
        if (win_wr && kind == K_ID) ctl_d.id = bus_wdata[27:24];

        for (int i = 0; i < NUM_PINS; i++) begin
            e     = tbl_q[i];
            raise = 1'b0;

            if (win_wr && kind == K_ENT && int'(ent_idx) == i) begin
                if (ent_hi) begin
                    // R6: upper word holds only the destination
                    e.dest = bus_wdata[31:24];
                end else begin
                    // R6: in-service flag kept, delivery status forced low
                    e.vec   = bus_wdata[7:0];
                    e.dlv   = bus_wdata[10:8];
                    e.dmode = bus_wdata[11];
                    e.dstat = 1'b0;
                    e.pol   = bus_wdata[13];
                    e.level = bus_wdata[15];
                    e.mask  = bus_wdata[16];
                    // R7: post-write resolution with the new polarity (R10)
                    if (!e.level) begin
                        e.in_svc = 1'b0;
                    end else if (!e.mask && !e.in_svc && (irq_in[i] ^ e.pol)) begin
                        e.in_svc = 1'b1;
                        raise    = 1'b1;
                    end
                end
            end

            // R9: EOI by vector
            if (eoi_wr && e.vec == bus_wdata[7:0]) begin
                e.in_svc = 1'b0;
                if (e.level && !e.mask && asserted[i]) begin
                    e.in_svc = 1'b1;
                    raise    = 1'b1;
                end
            end

            // R8: rising assertion
            if (rise[i] && !e.mask) begin
                if (!e.level) begin
                    raise = 1'b1;
                end else if (!e.in_svc) begin
                    e.in_svc = 1'b1;
                    raise    = 1'b1;
                end
            end

            tbl_d[i] = e;
            if (raise) pend_d[i] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            pend_q <= '0;
            for (int i = 0; i < NUM_PINS; i++) tbl_q[i] <= RTE_RESET;
        end else begin
            ctl_q  <= ctl_d;
            pend_q <= pend_d;
            for (int i = 0; i < NUM_PINS; i++) tbl_q[i] <= tbl_d[i];
        end
    end

    // Read path
    always_comb begin
        win_ent = tbl_q[ent_idx];
        bus_rdata = '0;
        case (bus_addr)
            OFF_SEL: bus_rdata = {24'h0, ctl_q.sel};
            OFF_WIN: begin
                case (kind)
                    K_ID, K_ARB: bus_rdata = {4'h0, ctl_q.id, 24'h0};
                    K_VER:       bus_rdata = VER_WORD;
                    K_ENT:       bus_rdata = ent_hi ? {win_ent.dest, 24'h0}
                                                    : {15'h0, win_ent[16:0]};
                    default:     bus_rdata = '0;
                endcase
            end
            default: bus_rdata = '0;
        endcase
    end

    // Delivery port
    assign gnt_ent       = tbl_q[gnt_idx];
    assign dlv_valid     = gnt_valid;
    assign dlv_pin       = gnt_idx;
    assign dlv_vector    = gnt_ent.vec;
    assign dlv_mode      = gnt_ent.dlv;
    assign dlv_dest_mode = gnt_ent.dmode;
    assign dlv_dest      = gnt_ent.dest;
    assign dlv_level     = gnt_ent.level;

endmodule

// File: rtl/irq_redir_chk.sv
module irq_redir_chk #(
    parameter int         NUM_PINS = 24,
    parameter int         PIN_W    = 5,
    parameter logic [7:0] VERSION  = 8'h20
) (
    input logic                clk,
    input logic                rst_n,
    input logic [7:0]          bus_addr,
    input logic [31:0]         bus_rdata,
    input logic [7:0]          sel,
    input logic [NUM_PINS-1:0] pend,
    input logic                dlv_valid,
    input logic                dlv_ready,
    input logic [PIN_W-1:0]    dlv_pin
);

    localparam logic [31:0] VER_EXP = {8'h00, 8'(NUM_PINS - 1), 8'h00, VERSION};

    logic [NUM_PINS-1:0] below;
    assign below = (NUM_PINS'(1) << dlv_pin) - NUM_PINS'(1);

    p_valid_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_valid && !dlv_ready) |=> dlv_valid);

    p_lowest_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid |-> (((pend & below) == '0) && pend[dlv_pin]));

    p_pin_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid |-> (int'(dlv_pin) < NUM_PINS));

    p_dstat_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 8'h10 && sel >= 8'h10 && !sel[0]) |-> !bus_rdata[12]);

    p_ver_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 8'h10 && sel == 8'h01) |-> (bus_rdata == VER_EXP));

    p_sel_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 8'h00) |-> (bus_rdata == {24'h0, sel}));

endmodule

bind irq_redir_ctrl irq_redir_chk #(
    .NUM_PINS (NUM_PINS),
    .PIN_W    (PIN_W),
    .VERSION  (VERSION)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .sel       (sel_cur),
    .pend      (pend_q),
    .dlv_valid (dlv_valid),
    .dlv_ready (dlv_ready),
    .dlv_pin   (dlv_pin)
);

// File: tb/irq_redir_ctrl_bench.sv
module irq_redir_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NP         = 4;
    localparam int PW         = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_addr = 8'h00;
    logic [31:0]   bus_wdata = 32'h0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] irq_in = '0;
    logic          dlv_valid;
    logic          dlv_ready = 1'b0;
    logic [PW-1:0] dlv_pin;
    logic [7:0]    dlv_vector;
    logic [2:0]    dlv_mode;
    logic          dlv_dest_mode;
    logic [7:0]    dlv_dest;
    logic          dlv_level;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_redir_ctrl #(.NUM_PINS(NP)) u_irq_redir_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_wr        (bus_wr),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .irq_in        (irq_in),
        .dlv_valid     (dlv_valid),
        .dlv_ready     (dlv_ready),
        .dlv_pin       (dlv_pin),
        .dlv_vector    (dlv_vector),
        .dlv_mode      (dlv_mode),
        .dlv_dest_mode (dlv_dest_mode),
        .dlv_dest      (dlv_dest),
        .dlv_level     (dlv_level)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 8'h00;
        #1;
    endtask

    task automatic wr_idx(input logic [7:0] idx, input logic [31:0] d);
        wr(8'h00, {24'h0, idx});
        wr(8'h10, d);
    endtask

    task automatic rd_idx(input logic [7:0] idx, output logic [31:0] d);
        wr(8'h00, {24'h0, idx});
        bus_addr = 8'h10;
        #1;
        d = bus_rdata;
        bus_addr = 8'h00;
    endtask

    task automatic chk_idx(input string req, input logic [7:0] idx, input logic [31:0] exp);
        logic [31:0] d;
        rd_idx(idx, d);
        chk(req, d, exp);
    endtask

    task automatic line(input int i, input logic v);
        @(negedge clk);
        irq_in[i] = v;
        @(negedge clk);
        #1;
    endtask

    task automatic accept();
        @(negedge clk);
        dlv_ready = 1'b1;
        @(negedge clk);
        dlv_ready = 1'b0;
        #1;
    endtask

    task automatic chk_dlv(input string req, input logic v, input int pin, input logic [7:0] vec);
        chk(req, {31'h0, dlv_valid}, {31'h0, v});
        if (v) begin
            chk(req, {30'h0, dlv_pin}, 32'(pin));
            chk(req, {24'h0, dlv_vector}, {24'h0, vec});
        end
    endtask

    task automatic t_reset();
        chk_dlv("R12 no request after reset", 1'b0, 0, 8'h0);
        chk_idx("R12 ID reset", 8'h00, 32'h0);
        chk_idx("R2 version word", 8'h01, 32'h0003_0020);
        chk_idx("R12 entry low reset", 8'h10, 32'h0001_0000);
        chk_idx("R12 entry high reset", 8'h17, 32'h0);
    endtask

    task automatic t_select();
        wr(8'h00, 32'h0000_0013);
        bus_addr = 8'h00; #1;
        chk("R1 index readback", bus_rdata, 32'h13);
        bus_addr = 8'h20; #1;
        chk("R1 unmapped offset reads zero", bus_rdata, 32'h0);
        bus_addr = 8'h00;
    endtask

    task automatic t_id();
        wr_idx(8'h01, 32'hFFFF_FFFF);
        chk_idx("R2 version ignores writes", 8'h01, 32'h0003_0020);
        wr_idx(8'h00, 32'hFA00_0000);
        chk_idx("R3 ID write", 8'h00, 32'h0A00_0000);
        chk_idx("R3 arbitration ID mirrors", 8'h02, 32'h0A00_0000);
        wr_idx(8'h02, 32'h0500_0000);
        chk_idx("R3 arbitration ID ignores writes", 8'h00, 32'h0A00_0000);
    endtask

    task automatic t_entry();
        wr_idx(8'h12, 32'h0000_5931);
        chk_idx("R6 low write read-only bits", 8'h12, 32'h0000_0931);
        wr_idx(8'h13, 32'hAB00_0000);
        chk_idx("R4 high word destination", 8'h13, 32'hAB00_0000);
        chk_idx("R6 high write keeps low word", 8'h12, 32'h0000_0931);
        wr_idx(8'h18, 32'hFFFF_FFFF);
        chk_idx("R5 out-of-range reads zero", 8'h18, 32'h0);
        chk_idx("R5 out-of-range write ignored", 8'h16, 32'h0001_0000);
        chk_idx("R5 out-of-range write ignored hi", 8'h17, 32'h0);
        chk_dlv("R6 no delivery from programming", 1'b0, 0, 8'h0);
    endtask

    task automatic t_edge();
        line(1, 1'b1);
        chk_dlv("R8 edge pin delivers", 1'b1, 1, 8'h31);
        chk("R11 routing fields", {8'h0, dlv_dest, 5'h0, dlv_mode, 6'h0, dlv_dest_mode, dlv_level},
            {8'h0, 8'hAB, 5'h0, 3'b001, 6'h0, 1'b1, 1'b0});
        accept();
        chk_dlv("R11 accepted request drops", 1'b0, 0, 8'h0);
        line(1, 1'b0);
        line(1, 1'b1);
        chk_dlv("R8 edge pin delivers again", 1'b1, 1, 8'h31);
        accept();
        line(1, 1'b0);
        chk_idx("R8 edge pin flag stays clear", 8'h12, 32'h0000_0931);
    endtask

    task automatic t_level();
        line(2, 1'b1);
        chk_dlv("R8 masked pin ignored", 1'b0, 0, 8'h0);
        wr_idx(8'h14, 32'h0000_8042);
        chk_dlv("R7 unmask of asserted level pin delivers", 1'b1, 2, 8'h42);
        accept();
        chk_idx("R7 flag set by write delivery", 8'h14, 32'h0000_C042);
        line(2, 1'b0);
        line(2, 1'b1);
        chk_dlv("R8 level pin blocked while in service", 1'b0, 0, 8'h0);
        wr(8'h40, 32'h42);
        chk_dlv("R9 EOI redelivers asserted level pin", 1'b1, 2, 8'h42);
        accept();
        wr(8'h40, 32'h99);
        chk_idx("R9 other vector leaves flag", 8'h14, 32'h0000_C042);
        line(2, 1'b0);
        wr(8'h40, 32'h42);
        chk_dlv("R9 EOI of idle line no delivery", 1'b0, 0, 8'h0);
        chk_idx("R9 EOI clears flag", 8'h14, 32'h0000_8042);
    endtask

    task automatic t_to_edge();
        line(2, 1'b1);
        chk_dlv("R8 level rise with flag clear", 1'b1, 2, 8'h42);
        accept();
        wr_idx(8'h14, 32'h0000_0042);
        chk_dlv("R7 switch to edge no delivery", 1'b0, 0, 8'h0);
        chk_idx("R7 switch to edge clears flag", 8'h14, 32'h0000_0042);
        line(2, 1'b0);
    endtask

    task automatic t_hi_nodlv();
        wr_idx(8'h14, 32'h0001_8042);
        line(2, 1'b1);
        wr_idx(8'h15, 32'h0700_0000);
        chk_dlv("R6 high write never delivers", 1'b0, 0, 8'h0);
        wr_idx(8'h14, 32'h0000_8042);
        chk_dlv("R7 low write delivers", 1'b1, 2, 8'h42);
        chk("R6 new destination presented", {24'h0, dlv_dest}, 32'h07);
        accept();
        line(2, 1'b0);
        wr(8'h40, 32'h42);
        wr_idx(8'h14, 32'h0001_0042);
        chk_dlv("R9 cleanup idle", 1'b0, 0, 8'h0);
    endtask

    task automatic t_polarity();
        wr_idx(8'h16, 32'h0000_A055);
        chk_dlv("R10 active-low level pin delivers at low input", 1'b1, 3, 8'h55);
        accept();
        chk_idx("R10 flag set", 8'h16, 32'h0000_E055);
        line(3, 1'b1);
        wr(8'h40, 32'h55);
        chk_dlv("R10 high input is deasserted", 1'b0, 0, 8'h0);
        chk_idx("R10 flag cleared by EOI", 8'h16, 32'h0000_A055);
    endtask

    task automatic t_priority();
        wr_idx(8'h10, 32'h0000_0020);
        @(negedge clk);
        irq_in[0] = 1'b1; irq_in[1] = 1'b1;
        @(negedge clk); #1;
        chk_dlv("R11 lowest pin first", 1'b1, 0, 8'h20);
        repeat (3) @(negedge clk);
        #1;
        chk_dlv("R11 request held until accepted", 1'b1, 0, 8'h20);
        accept();
        chk_dlv("R11 next pending pin", 1'b1, 1, 8'h31);
        accept();
        chk_dlv("R11 all served", 1'b0, 0, 8'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_select();
        t_id();
        t_entry();
        t_edge();
        t_level();
        t_to_edge();
        t_hi_nodlv();
        t_polarity();
        t_priority();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule